// File: doc/BRIEF.md
# Fault-Injectable Gamma Network Fabric

This block is a cycle-level model of a multistage gamma-style switching fabric joining N = 2^LOG_N ports, with eight ports by default. A packet enters at a source port together with a routing tag. The packet then moves forward by exactly one switch stage on every clock. No packet waits on another, so a new packet may enter on every cycle.

The first stage is different from the others. Each pair of neighbouring inputs, 2k and 2k+1, shares one entry switch with four outgoing links, and a two-bit code selects one of those links. Every later stage i has three links per switch position. One goes straight, one goes forward by 2^i and one goes back by 2^i, with all arithmetic modulo N. A signed tag digit selects among these three links.

Fault-mask inputs mark single links as broken. When the selected link is broken, the packet is dropped and the fabric reports the stage where the packet stopped. An illegal digit also stops the packet, and it is reported on its own flag. The fabric does not arbitrate between packets, it has no buffers and it does not compute tags.

Top module: `gamma_fabric`

## Requirements
- R1: After reset, and after a reset that lands while a packet is in flight, out_valid, blk_fault and blk_illegal are all zero, and no packet that entered before the reset ever comes out.
- R2: A packet accepted at a clock edge with a legal tag and no fault on its path raises out_valid for exactly one cycle. That cycle begins LOG_N+1 edges after acceptance, counting the accepting edge as the first.
- R3: in_tag[1:0] is the entry code c. For source s, with base = s with its lowest bit cleared, code c leads to stage-1 switch (base + c - 1) mod N. So 00 leads to base-1, 01 to base, 10 to base+1 and 11 to base+2.
- R4: in_tag[2i+1:2i] is the digit for stage i (1 <= i < LOG_N). The value 00 takes the straight link, 01 takes the link to (j + 2^i) mod N and 11 takes the link to (j - 2^i) mod N. out_port is the switch that the last digit reaches.
- R5: fault_entry bit 4k+c marks entry-switch k, code c, as broken. A packet that selects that link is dropped, and blk_fault[0] pulses for one cycle, 2 edges after acceptance.
- R6: fault_mid bit ((i-1)*N + j)*3 + d marks a broken link at stage i, switch j, where d = 0 is the minus link, 1 is straight and 2 is plus. A packet that selects that link is dropped, and blk_fault[i] pulses, i+2 edges after acceptance.
- R7: A fault bit on a link that the packet does not select has no effect on its arrival or its port. This holds even when that link leads to the same switch as the selected link.
- R8: The digit 10 is illegal. It drops the packet and pulses blk_illegal[i] with the same timing as R6. It takes precedence over a fault on the same stage, so blk_fault[i] stays low.
- R9: Packets accepted on consecutive edges travel independently and come out on consecutive cycles, each with its own port.
- R10: A dropped packet never raises out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet offered this cycle |
| in_src | input | LOG_N | Source port of the packet |
| in_tag | input | 2*LOG_N | Entry code in bits [1:0], then one two-bit digit per intermediate stage |
| fault_entry | input | 2*N | One bit per entry-switch link, index 4k+c |
| fault_mid | input | (LOG_N-1)*3*N | One bit per intermediate link, index ((i-1)*N+j)*3+d |
| out_valid | output | 1 | A packet reached the last stage |
| out_port | output | LOG_N | Port the packet reached |
| blk_fault | output | LOG_N | Bit i pulses when a packet was dropped by a faulty link leaving stage i |
| blk_illegal | output | LOG_N | Bit i pulses when a packet was dropped by an illegal digit at stage i |

## Verification
The bench builds the fabric with LOG_N = 3, which gives eight ports, four entry switches and two intermediate stages with strides 2 and 4. At the stride-4 stage, the plus and minus links reach the same switch, so a fault on the link that is not taken can be placed right beside the link that is taken. Both ends of the modulo wrap, and all four entry codes, can be reached with a handful of hand-worked vectors. Drops can be placed at every stage, so each timing of the blocked report is exercised.

// File: rtl/gamma_fabric_pkg.sv
package gamma_fabric_pkg;
    // two-bit signed digit encoding used by intermediate stages
    localparam logic [1:0] DIG_ZERO  = 2'b00;
    localparam logic [1:0] DIG_PLUS  = 2'b01;
    localparam logic [1:0] DIG_MINUS = 2'b11;

    // link numbering inside one intermediate switch
    localparam int LNK_MINUS    = 0;
    localparam int LNK_STRAIGHT = 1;
    localparam int LNK_PLUS     = 2;
    localparam int LNK_PER_SW   = 3;

    // links per shared entry switch
    localparam int ENTRY_LNK    = 4;
endpackage

// File: rtl/gamma_fabric_entry.sv
module gamma_fabric_entry
    import gamma_fabric_pkg::*;
#(
    parameter int LOG_N = 3,
    localparam int N    = 1 << LOG_N
) (
    input  logic [LOG_N-1:0]       pos,
    input  logic [1:0]             code,
    input  logic [N/2*ENTRY_LNK-1:0] flt_vec,
    output logic [LOG_N-1:0]       nxt_pos,
    output logic                   link_bad
);
    logic [LOG_N-1:0] base;
    int               idx;

    always_comb begin
        base     = pos & ~LOG_N'(1);
        nxt_pos  = base + LOG_N'(code) - LOG_N'(1);
        idx      = int'(pos >> 1) * ENTRY_LNK + int'(code);
        link_bad = flt_vec[idx];
    end
endmodule

// File: rtl/gamma_fabric_hop.sv
module gamma_fabric_hop
    import gamma_fabric_pkg::*;
#(
    parameter int LOG_N = 3,
    parameter int STG   = 1,
    localparam int N    = 1 << LOG_N
) (
    input  logic [LOG_N-1:0]         pos,
    input  logic [1:0]               dig,
    input  logic [N*LNK_PER_SW-1:0]  flt_vec,
    output logic [LOG_N-1:0]         nxt_pos,
    output logic                     link_bad,
    output logic                     dig_bad
);
    localparam logic [LOG_N-1:0] STEP = LOG_N'(1 << STG);

    int dir;

    always_comb begin
        dig_bad = 1'b0;
        dir     = LNK_STRAIGHT;
        nxt_pos = pos;
        case (dig)
            DIG_ZERO: begin
                dir     = LNK_STRAIGHT;
                nxt_pos = pos;
            end
            DIG_PLUS: begin
                dir     = LNK_PLUS;
                nxt_pos = pos + STEP;
            end
            DIG_MINUS: begin
                dir     = LNK_MINUS;
                nxt_pos = pos - STEP;
            end
            default: dig_bad = 1'b1;
        endcase
        link_bad = !dig_bad && flt_vec[int'(pos) * LNK_PER_SW + dir];
    end
endmodule

// File: rtl/gamma_fabric.sv
module gamma_fabric
    import gamma_fabric_pkg::*;
#(
    parameter int  LOG_N  = 3,
    localparam int N      = 1 << LOG_N,
    localparam int NSTG   = LOG_N + 1,
    localparam int TAG_W  = 2 * LOG_N,
    localparam int FE_W   = N / 2 * ENTRY_LNK,
    localparam int FM_ST  = N * LNK_PER_SW,
    localparam int FM_W   = (LOG_N - 1) * FM_ST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [LOG_N-1:0] in_src,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [FE_W-1:0]  fault_entry,
    input  logic [FM_W-1:0]  fault_mid,
    output logic             out_valid,
    output logic [LOG_N-1:0] out_port,
    output logic [LOG_N-1:0] blk_fault,
    output logic [LOG_N-1:0] blk_illegal
);
    typedef struct packed {
        logic [NSTG-1:0]                vld;
        logic [NSTG-1:0][LOG_N-1:0]     pos;
        logic [LOG_N-1:0][TAG_W-1:0]    tag;
        logic [LOG_N-1:0]               blk_flt;
        logic [LOG_N-1:0]               blk_ill;
    } fab_st_t;

    fab_st_t st_d, st_q;

    logic [LOG_N-1:0] step_pos [LOG_N];
    logic             step_flt [LOG_N];
    logic             step_ill [LOG_N];

    // stage 0: shared entry switches
    gamma_fabric_entry #(.LOG_N(LOG_N)) u_entry (
        .pos      (st_q.pos[0]),
        .code     (st_q.tag[0][1:0]),
        .flt_vec  (fault_entry),
        .nxt_pos  (step_pos[0]),
        .link_bad (step_flt[0])
    );
    assign step_ill[0] = 1'b0;

    // stages 1 .. LOG_N-1: three-way power-of-two hops
    for (genvar g = 1; g < LOG_N; g++) begin : g_hop
        gamma_fabric_hop #(.LOG_N(LOG_N), .STG(g)) u_hop (
            .pos      (st_q.pos[g]),
            .dig      (st_q.tag[g][2*g+1:2*g]),
            .flt_vec  (fault_mid[(g-1)*FM_ST +: FM_ST]),
            .nxt_pos  (step_pos[g]),
            .link_bad (step_flt[g]),
            .dig_bad  (step_ill[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.vld[0] = in_valid;
        st_d.pos[0] = in_src;
        st_d.tag[0] = in_tag;
        for (int s = 0; s < LOG_N; s++) begin
            st_d.vld[s+1]   = st_q.vld[s] && !step_flt[s] && !step_ill[s];
            st_d.pos[s+1]   = step_pos[s];
            st_d.blk_flt[s] = st_q.vld[s] && step_flt[s] && !step_ill[s];
            st_d.blk_ill[s] = st_q.vld[s] && step_ill[s];
            if (s < LOG_N - 1) begin
                st_d.tag[s+1] = st_q.tag[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // last stored tag is only partly consumed by the final hop
    logic unused_tail_tag;
    assign unused_tail_tag = ^st_q.tag[LOG_N-1];

    assign out_valid   = st_q.vld[LOG_N];
    assign out_port    = st_q.pos[LOG_N];
    assign blk_fault   = st_q.blk_flt;
    assign blk_illegal = st_q.blk_ill;
endmodule

// File: rtl/gamma_fabric_chk.sv
module gamma_fabric_chk #(
    parameter int LOG_N = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             out_valid,
    input logic [LOG_N-1:0] blk_fault,
    input logic [LOG_N-1:0] blk_illegal
);
    // hist[k]: a packet was offered k+1 edges ago (since reset)
    logic [LOG_N:0] hist;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist <= '0;
        end else begin
            hist <= {hist[LOG_N-1:0], in_valid};
        end
    end

    // R2: an arrival needs an offer exactly LOG_N+1 edges earlier
    assert_arrive_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> hist[LOG_N]);

    // R9: no follower packet means the output pulse ends
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !hist[LOG_N-1]) |=> !out_valid);

    // R8: illegal digit wins over a fault at the same stage
    assert_ill_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_fault & blk_illegal) == '0);

    // R10: a drop at the last hop never coincides with an arrival
    assert_drop_no_arrive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_fault[LOG_N-1] || blk_illegal[LOG_N-1]) |-> !out_valid);

    for (genvar s = 0; s < LOG_N; s++) begin : g_drop
        // R6: a stage-s drop report needs an offer s+2 edges earlier
        assert_drop_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (blk_fault[s] || blk_illegal[s]) |-> hist[s+1]);
    end
endmodule

bind gamma_fabric gamma_fabric_chk #(.LOG_N(LOG_N)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .blk_fault   (blk_fault),
    .blk_illegal (blk_illegal)
);

// File: tb/gamma_fabric_test.sv
`timescale 1ns/1ps
module gamma_fabric_test;
    localparam int LOG_N = 3;
    localparam int N     = 1 << LOG_N;
    localparam int TAG_W = 2 * LOG_N;
    localparam int FE_W  = 2 * N;
    localparam int FM_W  = (LOG_N - 1) * 3 * N;
    localparam int NV    = 14;

    // kind: 0 = arrives at val, 1 = fault drop at stage val, 2 = illegal at stage val
    // tag = {digit2, digit1, code}
    localparam int V_SRC  [NV] = '{2, 3, 7, 0, 6, 2, 2, 2, 2, 2, 2, 2, 5, 7};
    localparam int V_TAG  [NV] = '{6'b000101, 6'b011100, 6'b110011, 6'b000100,
                                   6'b111110, 6'b000101, 6'b000101, 6'b000101,
                                   6'b000101, 6'b001001, 6'b100101, 6'b000101,
                                   6'b010111, 6'b110011};
    localparam int V_FE   [NV] = '{-1, -1, -1, -1, -1, 5, 4, -1, -1, -1, -1, -1, -1, -1};
    localparam int V_FM   [NV] = '{-1, -1, -1, -1, -1, -1, -1, 8, 37, -1, 37, 7, -1, 26};
    localparam int V_KIND [NV] = '{0, 0, 0, 0, 0, 1, 0, 1, 1, 2, 2, 0, 0, 0};
    localparam int V_VAL  [NV] = '{4, 3, 4, 1, 1, 0, 4, 1, 2, 1, 2, 4, 4, 4};

    string v_req [NV] = '{"R4", "R3", "R3", "R3", "R4", "R5", "R7", "R6",
                          "R6", "R8", "R8", "R7", "R4", "R7"};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [LOG_N-1:0] in_src = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [FE_W-1:0]  fault_entry = '0;
    logic [FM_W-1:0]  fault_mid = '0;
    logic             out_valid;
    logic [LOG_N-1:0] out_port;
    logic [LOG_N-1:0] blk_fault;
    logic [LOG_N-1:0] blk_illegal;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #10 clk = ~clk;

    gamma_fabric #(.LOG_N(LOG_N)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_src      (in_src),
        .in_tag      (in_tag),
        .fault_entry (fault_entry),
        .fault_mid   (fault_mid),
        .out_valid   (out_valid),
        .out_port    (out_port),
        .blk_fault   (blk_fault),
        .blk_illegal (blk_illegal)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk(out_valid == 1'b0, req, "out_valid idle", int'(out_valid), 0);
        chk(blk_fault == '0, req, "blk_fault idle", int'(blk_fault), 0);
        chk(blk_illegal == '0, req, "blk_illegal idle", int'(blk_illegal), 0);
    endtask

    // one packet, checked on every cycle until it must have left the fabric
    task automatic run_pkt(input int src, input int tag, input int fe, input int fm,
                           input int kind, input int val, input string req);
        @(negedge clk);
        fault_entry = '0;
        fault_mid   = '0;
        if (fe >= 0) fault_entry[fe] = 1'b1;
        if (fm >= 0) fault_mid[fm] = 1'b1;
        in_valid = 1'b1;
        in_src   = LOG_N'(src);
        in_tag   = TAG_W'(tag);
        for (int c = 1; c <= LOG_N + 2; c++) begin
            logic             e_ov;
            logic [LOG_N-1:0] e_bf;
            logic [LOG_N-1:0] e_bi;
            @(posedge clk);
            @(negedge clk);
            if (c == 1) in_valid = 1'b0;
            e_ov = (kind == 0) && (c == LOG_N + 1);
            e_bf = ((kind == 1) && (c == val + 2)) ? LOG_N'(1 << val) : '0;
            e_bi = ((kind == 2) && (c == val + 2)) ? LOG_N'(1 << val) : '0;
            chk(out_valid == e_ov, req, "out_valid", int'(out_valid), int'(e_ov));
            if (e_ov) chk(out_port == LOG_N'(val), req, "out_port", int'(out_port), val);
            chk(blk_fault == e_bf, req, "blk_fault", int'(blk_fault), int'(e_bf));
            chk(blk_illegal == e_bi, req, "blk_illegal", int'(blk_illegal), int'(e_bi));
        end
        fault_entry = '0;
        fault_mid   = '0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk_idle("R1");

        // table walk (R2 timing checked on every vector)
        for (int v = 0; v < NV; v++) begin
            run_pkt(V_SRC[v], V_TAG[v], V_FE[v], V_FM[v], V_KIND[v], V_VAL[v], v_req[v]);
        end

        // R9: back-to-back packets, src2 -> 4 then src3 -> 3
        @(negedge clk);
        in_valid = 1'b1; in_src = 3'd2; in_tag = 6'b000101;
        @(posedge clk); @(negedge clk);
        in_src = 3'd3; in_tag = 6'b011100;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        for (int c = 2; c <= LOG_N + 3; c++) begin
            if (c == LOG_N + 1) begin
                chk(out_valid && out_port == 3'd4, "R9", "first of pair",
                    int'(out_port), 4);
            end else if (c == LOG_N + 2) begin
                chk(out_valid && out_port == 3'd3, "R9", "second of pair",
                    int'(out_port), 3);
            end else begin
                chk(!out_valid, "R9", "no extra arrival", int'(out_valid), 0);
            end
            @(posedge clk); @(negedge clk);
        end

        // R10: first packet dropped at stage 2, second still arrives
        @(negedge clk);
        fault_mid[37] = 1'b1;
        in_valid = 1'b1; in_src = 3'd2; in_tag = 6'b000101;
        @(posedge clk); @(negedge clk);
        in_src = 3'd3; in_tag = 6'b011100;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        for (int c = 2; c <= LOG_N + 3; c++) begin
            if (c == LOG_N + 1) begin
                chk(!out_valid, "R10", "dropped packet arrived", int'(out_valid), 0);
                chk(blk_fault == 3'b100, "R10", "drop report", int'(blk_fault), 4);
            end else if (c == LOG_N + 2) begin
                chk(out_valid && out_port == 3'd3, "R10", "survivor arrival",
                    int'(out_port), 3);
            end
            @(posedge clk); @(negedge clk);
        end
        fault_mid = '0;

        // R1: reset while a packet is in flight
        @(negedge clk);
        in_valid = 1'b1; in_src = 3'd2; in_tag = 6'b000101;
        @(posedge clk); @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < LOG_N + 2; c++) begin
            chk_idle("R1");
            @(posedge clk); @(negedge clk);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule